// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Device Model

This block is a synthesizable model of a small serial EEPROM that answers a three-wire host bus made of a chip select, a serial clock and a data input, plus a data output with its own enable. A fast system clock oversamples the three bus inputs. The bus clock is therefore treated as data, and every action is taken on a detected edge of it. A frame opens with a 1 start bit. Next come a two-bit opcode and an address, and a data word follows for the commands that store data. Frames without an address-level target use opcode 00 and carry a sub-command in the two leading address bits.

Stores do not happen while the frame is being shifted in. A store, clear or bulk command is only queued. It starts when chip select drops, then runs for a fixed number of system clocks with no bus-clock activity needed. While chip select is high during or after that cycle, the data output reports busy or ready. A static organisation input picks 64 words of 16 bits or 128 bytes of 8 bits. Both views map onto the same storage.

Top module: `serial_eeprom_model`

## Requirements
- R1: After reset the output enable is low, the write-enable latch is clear, no status is shown while selected, and every location reads as all ones.
- R2: A read (opcode 10, DI sampled on bus-clock rising edges, fields MSB first, 6 address bits when orgWide=1) enables DO after the last address bit and presents a 0 first. It then presents the addressed 16-bit word MSB first, one bit per bus-clock rising edge.
- R3: While chip select stays high after a read, further rising edges stream the following words with no leading 0. The address wraps from the last location to location 0.
- R4: A write (opcode 01, address, then data) with the latch set stores the data only after chip select falls. It needs no bus-clock edges after that.
- R5: With the latch clear, whether after reset or after sub-command 00 under opcode 00, no store or clear takes place and no busy cycle starts. Reads still work.
- R6: A clear (opcode 11, address) with the latch set leaves that location reading as all ones.
- R7: Under opcode 00, sub-command 10 sets every location to all ones. Sub-command 01, followed by a data word, writes that word into every location. Sub-command 11 sets the write-enable latch.
- R8: With orgWide=0, addresses are 7 bits and data is 8 bits. Byte address b maps to word b>>1: odd b selects bits 15:8 and even b selects bits 7:0. Sequential byte reads wrap from 127 to 0.
- R9: While chip select is high during a program cycle, DO is enabled and low. Once the cycle ends, DO is high. A 1 clocked in on DI disables DO after the next bus-clock falling edge.
- R10: Frames received while a program cycle runs are ignored.
- R11: Leading 0s before the start bit are skipped. Dropping chip select part-way through a frame discards it, and no store follows.
- R12: DO is never enabled while chip select is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rstN | input | 1 | Active-low asynchronous reset |
| orgWide | input | 1 | 1: 16-bit words, 0: 8-bit bytes |
| csIn | input | 1 | Chip select, active high |
| skIn | input | 1 | Serial bus clock |
| diIn | input | 1 | Serial data in |
| doOut | output | 1 | Serial data out |
| doEn | output | 1 | Output enable for DO (0 = high impedance) |

## Verification
The checker watches four things on every system clock. It confirms that DO is never enabled without chip select seen high two clocks earlier. It confirms that a program cycle starts only after chip select has dropped, and only with the latch set. It also confirms that the latch does not move during a cycle and that DO reads low whenever it is enabled during one. The bench scenarios cover the rest: data values, the leading 0 that comes only before the first word, address wrap in both organisations, byte-lane mapping, the effect of abort and leading 0s, and the return of DO to high impedance after the status is dismissed.

// File: rtl/sem_pkg.sv
package sem_pkg;
  parameter int WORD_BITS      = 16;
  parameter int WORD_ADDR_BITS = 6;
  localparam int BYTE_ADDR_BITS = WORD_ADDR_BITS + 1;
  localparam int HALF_BITS      = WORD_BITS / 2;
  localparam int WORDS          = 1 << WORD_ADDR_BITS;
  localparam int CNT_BITS       = $clog2(WORD_BITS + 1);

  typedef enum logic [2:0] {
    OP_NONE, OP_WRITE, OP_ERASE, OP_ERASE_ALL, OP_WRITE_ALL
  } progOp_e;

  typedef struct packed {
    logic                      loadRead;
    logic                      withDummy;
    logic                      shiftRead;
    logic                      commit;
    progOp_e                   op;
    logic [BYTE_ADDR_BITS-1:0] addr;
    logic [WORD_BITS-1:0]      data;
  } dpCtl_t;
endpackage

// File: rtl/sem_ctrl.sv
module sem_ctrl
  import sem_pkg::*;
#(
  parameter int PROG_CYCLES = 250000
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   orgWide,
  input  logic   csIn,
  input  logic   skIn,
  input  logic   diIn,
  input  logic   readBit,
  output dpCtl_t dpCtl,
  output logic   doOut,
  output logic   doEn,
  output logic   progBusy,
  output logic   writeEn
);
  localparam int PC_W = $clog2(PROG_CYCLES + 1);

  typedef enum logic [2:0] {
    ST_IDLE, ST_OPC, ST_ADDR, ST_DATA, ST_READ, ST_PEND, ST_HOLD
  } state_e;

  logic [1:0] csSh, skSh, diSh;
  logic       skPrev;
  logic       csS, diS, skRise, skFall;

  state_e                    state;
  logic [CNT_BITS-1:0]       bitCnt, remBits;
  logic [1:0]                opc;
  logic [BYTE_ADDR_BITS-1:0] addrSh, readAddr;
  logic [WORD_BITS-1:0]      dataSh;
  progOp_e                   pendOp;
  logic [PC_W-1:0]           busyCnt;
  logic                      statusShow, clrArm;

  logic [CNT_BITS-1:0]       addrLen, dataLen;
  logic [BYTE_ADDR_BITS-1:0] addrMask, addrNew, readNext;
  logic [1:0]                subCmd;
  logic                      lastAddr, lastData, cycleDone;

  // input synchronisers and bus-clock edge detection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csSh <= '0; skSh <= '0; diSh <= '0; skPrev <= 1'b0;
    end else begin
      csSh   <= {csSh[0], csIn};
      skSh   <= {skSh[0], skIn};
      diSh   <= {diSh[0], diIn};
      skPrev <= skSh[1];
    end
  end

  assign csS    = csSh[1];
  assign diS    = diSh[1];
  assign skRise = skSh[1] & ~skPrev;
  assign skFall = ~skSh[1] & skPrev;

  always_comb begin
    addrLen   = orgWide ? CNT_BITS'(WORD_ADDR_BITS) : CNT_BITS'(BYTE_ADDR_BITS);
    dataLen   = orgWide ? CNT_BITS'(WORD_BITS) : CNT_BITS'(HALF_BITS);
    addrMask  = orgWide ? BYTE_ADDR_BITS'(WORDS - 1) : '1;
    addrNew   = {addrSh[BYTE_ADDR_BITS-2:0], diS};
    subCmd    = orgWide ? addrNew[WORD_ADDR_BITS-1 -: 2] : addrNew[BYTE_ADDR_BITS-1 -: 2];
    readNext  = (readAddr + 1'b1) & addrMask;
    lastAddr  = (state == ST_ADDR) && (bitCnt == addrLen - 1'b1);
    lastData  = (state == ST_DATA) && (bitCnt == dataLen - 1'b1);
    cycleDone = progBusy && (busyCnt == PC_W'(PROG_CYCLES - 1));
  end

  // strobes towards the datapath
  always_comb begin
    dpCtl           = '0;
    dpCtl.op        = pendOp;
    dpCtl.addr      = addrSh;
    dpCtl.data      = dataSh;
    dpCtl.commit    = cycleDone;
    if (csS && skRise) begin
      if (lastAddr && opc == 2'b10) begin
        dpCtl.loadRead  = 1'b1;
        dpCtl.withDummy = 1'b1;
        dpCtl.addr      = addrNew;
      end else if (state == ST_READ) begin
        if (remBits == '0) begin
          dpCtl.loadRead = 1'b1;
          dpCtl.addr     = readNext;
        end else begin
          dpCtl.shiftRead = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      bitCnt     <= '0;
      remBits    <= '0;
      opc        <= '0;
      addrSh     <= '0;
      readAddr   <= '0;
      dataSh     <= '0;
      pendOp     <= OP_NONE;
      busyCnt    <= '0;
      progBusy   <= 1'b0;
      writeEn    <= 1'b0;
      statusShow <= 1'b0;
      clrArm     <= 1'b0;
    end else begin
      if (progBusy) begin
        if (cycleDone) progBusy <= 1'b0;
        else           busyCnt  <= busyCnt + 1'b1;
      end

      if (!csS) begin
        clrArm <= 1'b0;
        if (state == ST_PEND && writeEn && !progBusy) begin
          progBusy   <= 1'b1;
          busyCnt    <= '0;
          statusShow <= 1'b1;
        end
        state <= ST_IDLE;
      end else begin
        if (skRise && diS && statusShow) clrArm <= 1'b1;
        if (skFall && clrArm) begin
          statusShow <= 1'b0;
          clrArm     <= 1'b0;
        end
        if (skRise) begin
          unique case (state)
            ST_IDLE: if (diS && !progBusy) begin
              state  <= ST_OPC;
              bitCnt <= '0;
            end
            ST_OPC: begin
              opc    <= {opc[0], diS};
              bitCnt <= bitCnt + 1'b1;
              if (bitCnt == CNT_BITS'(1)) begin
                state  <= ST_ADDR;
                bitCnt <= '0;
              end
            end
            ST_ADDR: begin
              addrSh <= addrNew;
              bitCnt <= bitCnt + 1'b1;
              if (lastAddr) begin
                bitCnt <= '0;
                unique case (opc)
                  2'b10: begin
                    state    <= ST_READ;
                    readAddr <= addrNew & addrMask;
                    remBits  <= dataLen;
                  end
                  2'b01: begin state <= ST_DATA; pendOp <= OP_WRITE; end
                  2'b11: begin state <= ST_PEND; pendOp <= OP_ERASE; end
                  default: begin
                    unique case (subCmd)
                      2'b11: begin writeEn <= 1'b1; state <= ST_HOLD; end
                      2'b00: begin writeEn <= 1'b0; state <= ST_HOLD; end
                      2'b10: begin state <= ST_PEND; pendOp <= OP_ERASE_ALL; end
                      default: begin state <= ST_DATA; pendOp <= OP_WRITE_ALL; end
                    endcase
                  end
                endcase
              end
            end
            ST_DATA: begin
              dataSh <= {dataSh[WORD_BITS-2:0], diS};
              bitCnt <= bitCnt + 1'b1;
              if (lastData) state <= ST_PEND;
            end
            ST_READ: begin
              if (remBits == '0) begin
                readAddr <= readNext;
                remBits  <= dataLen - 1'b1;
              end else begin
                remBits <= remBits - 1'b1;
              end
            end
            default: ;
          endcase
        end
      end
    end
  end

  assign doEn  = csS && ((state == ST_READ) || statusShow);
  assign doOut = (state == ST_READ) ? readBit : ~progBusy;
endmodule

// File: rtl/sem_datapath.sv
module sem_datapath
  import sem_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   orgWide,
  input  dpCtl_t dpCtl,
  output logic   readBit
);
  logic [WORD_BITS-1:0]      memArr [WORDS];
  logic [WORD_BITS-1:0]      outShift, rawWord, alignedWord, fillWord;
  logic [WORD_ADDR_BITS-1:0] wordIdx;
  logic                      upperLane;

  always_comb begin
    wordIdx   = orgWide ? dpCtl.addr[WORD_ADDR_BITS-1:0] : dpCtl.addr[BYTE_ADDR_BITS-1:1];
    upperLane = dpCtl.addr[0];
    rawWord   = memArr[wordIdx];
    if (orgWide)        alignedWord = rawWord;
    else if (upperLane) alignedWord = {rawWord[WORD_BITS-1:HALF_BITS], HALF_BITS'(0)};
    else                alignedWord = {rawWord[HALF_BITS-1:0], HALF_BITS'(0)};
    fillWord = orgWide ? dpCtl.data : {2{dpCtl.data[HALF_BITS-1:0]}};
  end

  // serial output register: leading dummy 0 or MSB of the loaded word
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outShift <= '0;
      readBit  <= 1'b0;
    end else if (dpCtl.loadRead) begin
      if (dpCtl.withDummy) begin
        outShift <= alignedWord;
        readBit  <= 1'b0;
      end else begin
        outShift <= {alignedWord[WORD_BITS-2:0], 1'b0};
        readBit  <= alignedWord[WORD_BITS-1];
      end
    end else if (dpCtl.shiftRead) begin
      outShift <= {outShift[WORD_BITS-2:0], 1'b0};
      readBit  <= outShift[WORD_BITS-1];
    end
  end

  // storage: one word per generate slice, updated when a program cycle ends
  for (genvar gi = 0; gi < WORDS; gi++) begin : g_word
    logic hit;
    assign hit = (wordIdx == WORD_ADDR_BITS'(gi));
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        memArr[gi] <= '1;
      end else if (dpCtl.commit) begin
        unique case (dpCtl.op)
          OP_ERASE_ALL: memArr[gi] <= '1;
          OP_WRITE_ALL: memArr[gi] <= fillWord;
          OP_WRITE, OP_ERASE: if (hit) begin
            if (orgWide)
              memArr[gi] <= (dpCtl.op == OP_WRITE) ? dpCtl.data : '1;
            else if (upperLane)
              memArr[gi][WORD_BITS-1:HALF_BITS] <=
                (dpCtl.op == OP_WRITE) ? dpCtl.data[HALF_BITS-1:0] : '1;
            else
              memArr[gi][HALF_BITS-1:0] <=
                (dpCtl.op == OP_WRITE) ? dpCtl.data[HALF_BITS-1:0] : '1;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/serial_eeprom_model.sv
module serial_eeprom_model
  import sem_pkg::*;
#(
  parameter int PROG_CYCLES = 250000
) (
  input  logic clk,
  input  logic rstN,
  input  logic orgWide,
  input  logic csIn,
  input  logic skIn,
  input  logic diIn,
  output logic doOut,
  output logic doEn
);
  dpCtl_t dpCtl;
  logic   readBit;
  logic   progBusy;
  logic   writeEn;

  sem_ctrl #(.PROG_CYCLES(PROG_CYCLES)) uCtrl (
    .clk(clk), .rstN(rstN), .orgWide(orgWide), .csIn(csIn), .skIn(skIn),
    .diIn(diIn), .readBit(readBit), .dpCtl(dpCtl), .doOut(doOut),
    .doEn(doEn), .progBusy(progBusy), .writeEn(writeEn)
  );

  sem_datapath uDp (
    .clk(clk), .rstN(rstN), .orgWide(orgWide), .dpCtl(dpCtl), .readBit(readBit)
  );
endmodule

// File: rtl/sem_check.sv
module sem_check (
  input logic clk,
  input logic rstN,
  input logic csIn,
  input logic doOut,
  input logic doEn,
  input logic progBusy,
  input logic writeEn
);
  assert_out_needs_cs_R12: assert property (@(posedge clk) disable iff (!rstN)
    doEn |-> $past(csIn, 2));

  assert_busy_reads_low_R9: assert property (@(posedge clk) disable iff (!rstN)
    (doEn && progBusy) |-> !doOut);

  assert_cycle_needs_latch_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(progBusy) |-> writeEn);

  assert_cycle_after_cs_drop_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(progBusy) |-> !$past(csIn, 3));

  assert_latch_frozen_busy_R10: assert property (@(posedge clk) disable iff (!rstN)
    progBusy |-> $stable(writeEn));
endmodule

bind serial_eeprom_model sem_check uChk (
  .clk(clk), .rstN(rstN), .csIn(csIn), .doOut(doOut), .doEn(doEn),
  .progBusy(progBusy), .writeEn(writeEn)
);

// File: tb/test_serial_eeprom_model.sv
module test_serial_eeprom_model;
  localparam int PROG = 1000;

  logic clk = 1'b0;
  logic rstN, orgWide, csIn, skIn, diIn;
  logic doOut, doEn;
  int   total = 0;
  int   bad   = 0;

  typedef struct { logic b; string tag; } expItem_t;
  expItem_t expQ[$];
  event     sampleEv;

  logic [15:0] model [64];
  bit          benchWel;

  always #10 clk = ~clk;

  serial_eeprom_model #(.PROG_CYCLES(PROG)) i_serial_eeprom_model (
    .clk(clk), .rstN(rstN), .orgWide(orgWide), .csIn(csIn), .skIn(skIn),
    .diIn(diIn), .doOut(doOut), .doEn(doEn)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect16(input logic [15:0] act, input logic [15:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: compares DO against queued expectations
  always @(sampleEv) begin
    expItem_t it;
    it = expQ.pop_front();
    total++;
    if (doEn !== 1'b1 || doOut !== it.b) begin
      bad++;
      $display("FAIL %s: actual en=%b do=%b expected en=1 do=%b", it.tag, doEn, doOut, it.b);
    end
  end

  task automatic pulse(input logic d, input bit chk, input logic e, input string tag);
    diIn = d;
    tick(4);
    skIn = 1'b1;
    tick(8);
    if (chk) begin
      expQ.push_back('{e, tag});
      ->sampleEv;
    end
    skIn = 1'b0;
    tick(4);
  endtask

  function automatic int aw();
    return orgWide ? 6 : 7;
  endfunction
  function automatic int dw();
    return orgWide ? 16 : 8;
  endfunction
  function automatic logic [6:0] amask();
    return orgWide ? 7'h3F : 7'h7F;
  endfunction
  function automatic logic [6:0] subAddr(input logic [1:0] sub);
    return orgWide ? {1'b0, sub, 4'b0} : {sub, 5'b0};
  endfunction
  function automatic logic [15:0] modelGet(input logic [6:0] a);
    if (orgWide) return model[a[5:0]];
    return a[0] ? {8'h00, model[a[6:1]][15:8]} : {8'h00, model[a[6:1]][7:0]};
  endfunction

  task automatic sendBits(input logic [15:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) pulse(v[i], 0, 1'b0, "");
  endtask

  task automatic frame(input logic [1:0] op, input logic [6:0] a, input bit hasData,
                       input logic [15:0] d);
    csIn = 1'b1;
    tick(4);
    pulse(1'b1, 0, 1'b0, "");
    sendBits({14'b0, op}, 2);
    sendBits({9'b0, a}, aw());
    if (hasData) sendBits(d, dw());
  endtask

  task automatic endFrame();
    csIn = 1'b0;
    tick(6);
  endtask

  task automatic progCmd(input logic [1:0] op, input logic [6:0] a, input bit hasData,
                         input logic [15:0] d);
    frame(op, a, hasData, d);
    endFrame();
    tick(PROG + 30);
  endtask

  task automatic doRead(input logic [6:0] a, input int n, input int lead, input string tag);
    logic [15:0] w;
    csIn = 1'b1;
    tick(4);
    for (int i = 0; i < lead; i++) pulse(1'b0, 0, 1'b0, "");
    pulse(1'b1, 0, 1'b0, "");
    pulse(1'b1, 0, 1'b0, "");
    pulse(1'b0, 0, 1'b0, "");
    for (int i = aw() - 1; i >= 1; i--) pulse(a[i], 0, 1'b0, "");
    pulse(a[0], 1, 1'b0, {tag, " leading 0"});
    for (int k = 0; k < n; k++) begin
      w = modelGet((a + 7'(k)) & amask());
      for (int b = dw() - 1; b >= 0; b--) pulse(1'b0, 1, w[b], tag);
    end
    csIn = 1'b0;
    tick(6);
    expect16({15'b0, doEn}, 16'h0, "R12 DO disabled with CS low");
  endtask

  initial begin
    for (int i = 0; i < 64; i++) model[i] = 16'hFFFF;
    benchWel = 0;
    rstN = 1'b0; orgWide = 1'b1; csIn = 1'b0; skIn = 1'b0; diIn = 1'b0;
    tick(5);
    rstN = 1'b1;
    tick(4);

    // R1: reset state
    expect16({15'b0, doEn}, 16'h0, "R1 DO disabled after reset");
    csIn = 1'b1; tick(6);
    expect16({15'b0, doEn}, 16'h0, "R1 no status when selected after reset");
    csIn = 1'b0; tick(6);
    doRead(7'd5, 1, 0, "R1 erased read");

    // R5: write with latch clear does nothing
    progCmd(2'b01, 7'd3, 1, 16'hA5C3);
    csIn = 1'b1; tick(6);
    expect16({15'b0, doEn}, 16'h0, "R5 no cycle started while disabled");
    csIn = 1'b0; tick(6);
    doRead(7'd3, 1, 0, "R5 location unchanged");

    // R7 enable latch, then R4/R9 write with status polling
    frame(2'b00, subAddr(2'b11), 0, 16'h0); endFrame(); benchWel = 1;
    frame(2'b01, 7'd3, 1, 16'hA5C3);
    csIn = 1'b0; tick(4);
    csIn = 1'b1; tick(6);
    expect16({14'b0, doEn, doOut}, 16'h2, "R9 busy shown low");
    tick(PROG + 20);
    expect16({14'b0, doEn, doOut}, 16'h3, "R9 ready shown high");
    pulse(1'b1, 0, 1'b0, "");
    tick(4);
    expect16({15'b0, doEn}, 16'h0, "R9 DO released after dummy 1");
    csIn = 1'b0; tick(6);
    model[3] = 16'hA5C3;
    doRead(7'd3, 1, 0, "R4 stored word");
    doRead(7'd3, 1, 0, "R2 read MSB first");

    // R3 sequential read with wrap
    progCmd(2'b01, 7'd63, 1, 16'h1234); model[63] = 16'h1234;
    progCmd(2'b01, 7'd0, 1, 16'h8001);  model[0]  = 16'h8001;
    doRead(7'd62, 3, 0, "R3 streamed wrap");

    // R10 frame during busy is ignored
    frame(2'b01, 7'd7, 1, 16'h0000); endFrame(); model[7] = 16'h0000;
    progCmd(2'b01, 7'd8, 1, 16'h0000);
    doRead(7'd8, 1, 0, "R10 frame during busy ignored");
    doRead(7'd7, 1, 0, "R10 first write stored");

    // R6 clear one location
    progCmd(2'b11, 7'd3, 0, 16'h0); model[3] = 16'hFFFF;
    doRead(7'd3, 1, 0, "R6 cleared location");

    // R7 write-all then erase-all
    progCmd(2'b00, subAddr(2'b01), 1, 16'h5A5A);
    for (int i = 0; i < 64; i++) model[i] = 16'h5A5A;
    doRead(7'd10, 1, 0, "R7 write-all");
    progCmd(2'b00, subAddr(2'b10), 0, 16'h0);
    for (int i = 0; i < 64; i++) model[i] = 16'hFFFF;
    doRead(7'd0, 2, 0, "R7 erase-all");

    // R11 leading zeros and abort
    progCmd(2'b01, 7'd1, 1, 16'h0F0F); model[1] = 16'h0F0F;
    doRead(7'd1, 1, 3, "R11 leading zeros skipped");
    csIn = 1'b1; tick(4);
    pulse(1'b1, 0, 1'b0, "");
    sendBits(16'h1, 2);
    sendBits(16'd9, 6);
    sendBits(16'h00, 8);
    csIn = 1'b0; tick(6);
    csIn = 1'b1; tick(6);
    expect16({15'b0, doEn}, 16'h0, "R11 aborted frame starts no cycle");
    csIn = 1'b0; tick(PROG + 30);
    doRead(7'd9, 1, 0, "R11 aborted frame left data");

    // R8 byte organisation
    orgWide = 1'b0; tick(4);
    progCmd(2'b01, 7'd9, 1, 16'h003C); model[4][15:8] = 8'h3C;
    doRead(7'd9, 1, 0, "R8 odd byte");
    doRead(7'd8, 1, 0, "R8 even byte untouched");
    doRead(7'd127, 2, 0, "R8 byte wrap 127 to 0");
    orgWide = 1'b1; tick(4);
    doRead(7'd4, 1, 0, "R8 odd byte lands in bits 15:8");

    // R5 disable latch, later write ignored, read still works
    frame(2'b00, subAddr(2'b00), 0, 16'h0); endFrame(); benchWel = 0;
    progCmd(2'b01, 7'd5, 1, 16'h1111);
    progCmd(2'b00, subAddr(2'b10), 0, 16'h0);
    doRead(7'd5, 1, 0, "R5 write after disable ignored");
    doRead(7'd1, 1, 0, "R5 erase-all after disable ignored");

    tick(10);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule